// File: doc/BRIEF.md
# I2C Bank-Select Output and Alarm Slave

This block is a 7-bit-address I2C target that owns an 11-bit output port and reports an 11-bit alarm word. The outputs and alarms are split into two banks: a low bank of eight bits and a high bank of three bits. A bus controller picks the bank by writing a control byte right after the address, and then a data byte that is applied to that bank. A later read transfer returns the alarm bits of the bank last picked. Any other control code is accepted but leads nowhere: written data is dropped and reads return a fixed zero byte.

The SCL and SDA pins are modelled as open-drain lines. Each is a synchronized input plus a drive-low enable. After every acknowledged byte the block holds SCL low for a fixed number of clock cycles. The received byte is applied, or the next read byte is fetched, inside that window, so the controller never clocks ahead of the block's internal state.

Top module: `bank_io_slave`

## Requirements
- R1: Only the address byte 0x90/0x91 (7-bit address 0x48, bit 0 = read) is acknowledged. Any other address gets no ACK and no clock hold, and it leaves the outputs untouched.
- R2: Within a write, the first byte after the address is taken as the control byte and the second as the data byte. After the data byte the next byte counts as a control byte again.
- R3: With control 0x01, data bit i drives out_port[i] for i = 0..7, and out_port[10:8] keep their value.
- R4: With control 0x02, data bits 2..0 drive out_port[10:8]. Data bits 7..3 are ignored and out_port[7:0] keep their value.
- R5: With any control value other than 0x01 or 0x02, the data byte is discarded and no output bit changes.
- R6: A read byte carries alarm_in[7:0] for control 0x01, {5'b0, alarm_in[10:8]} for control 0x02, and 0x00 for any other control value. Bits are sent MSB first.
- R7: The stored control byte is cleared once a read byte has been fetched. A second byte in the same read, or a new read with no new control byte, returns 0x00.
- R8: After the ninth clock of every acknowledged byte, SCL is held low for exactly HOLD cycles. out_port changes only while that hold is active.
- R9: A START or STOP resets the control/data order, so the next written byte is a control byte. The stored control value itself is kept across a repeated START, so a read can follow.
- R10: The block drives ACK on the ninth clock for a matching address and for every written byte. On a read, a NACK from the controller ends the transfer with SDA released.
- R11: The drive-low enables of SDA change, and the SCL hold begins, only while SCL is low.
- R12: During and right after reset, out_port is zero and neither line is driven low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Sensed level of the SCL line |
| sda_i | input | 1 | Sensed level of the SDA line |
| scl_drive_low | output | 1 | When high, pulls SCL low (clock hold) |
| sda_drive_low | output | 1 | When high, pulls SDA low (ACK or a zero read bit) |
| alarm_in | input | 11 | Alarm status, bit k reported for channel k |
| out_port | output | 11 | Registered output bits, low bank [7:0], high bank [10:8] |

## Verification
The checks on line timing assume that SCL stays low and high for well over the three-cycle synchronizer latency. They also assume the controller moves SDA only while SCL is low, except when it forms a START or STOP, and that it waits for SCL to rise before timing a high phase. The bench's controller model keeps each SCL quarter-period at six clock cycles. It waits out any clock hold on the wired-AND bus before counting its high time. Random transfers mix valid and unknown control codes, data and alarm values, and all of them run under those same bus rules.

// File: rtl/bank_io_pkg.sv
package bank_io_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = 4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_WR,
    ST_ACK,
    ST_HOLD,
    ST_RD,
    ST_RD_ACK
  } xfer_state_t;
endpackage

// File: rtl/bank_io_line.sv
module bank_io_line #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic lvl,
  output logic lvl_q
);
  logic [STAGES-1:0] sr_q, sr_d;
  logic              last_q;

  always_comb sr_d = {sr_q[STAGES-2:0], pin};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q   <= '1;
      last_q <= 1'b1;
    end else begin
      sr_q   <= sr_d;
      last_q <= sr_q[STAGES-1];
    end
  end

  assign lvl   = sr_q[STAGES-1];
  assign lvl_q = last_q;
endmodule

// File: rtl/bank_io_engine.sv
module bank_io_engine
  import bank_io_pkg::*;
#(
  parameter logic [6:0] ADDR7 = 7'h48,
  parameter int         HOLD  = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_s,
  input  logic              scl_q,
  input  logic              sda_s,
  input  logic              sda_q,
  input  logic [BYTE_W-1:0] rd_byte,
  output logic              wr_evt,
  output logic              rd_evt,
  output logic              seq_rst,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              sda_low,
  output logic              scl_low
);
  localparam int HW = (HOLD < 2) ? 1 : $clog2(HOLD + 1);

  xfer_state_t       state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [BYTE_W-1:0] sh_q, sh_d;
  logic [HW-1:0]     hold_q, hold_d;
  logic              rw_q, rw_d, addr_q, addr_d, nack_q, nack_d;
  logic              sdl_q, sdl_d, scll_q, scll_d;

  logic scl_rise, scl_fall, start_c, stop_c;
  assign scl_rise = scl_s & ~scl_q;
  assign scl_fall = ~scl_s & scl_q;
  assign start_c  = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_c   = scl_s & scl_q & ~sda_q & sda_s;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    sh_d    = sh_q;
    hold_d  = hold_q;
    rw_d    = rw_q;
    addr_d  = addr_q;
    nack_d  = nack_q;
    sdl_d   = sdl_q;
    scll_d  = scll_q;
    wr_evt  = 1'b0;
    rd_evt  = 1'b0;
    seq_rst = 1'b0;
    if (start_c) begin
      state_d = ST_ADDR;
      cnt_d   = '0;
      sdl_d   = 1'b0;
      scll_d  = 1'b0;
      seq_rst = 1'b1;
    end else if (stop_c) begin
      state_d = ST_IDLE;
      sdl_d   = 1'b0;
      scll_d  = 1'b0;
      seq_rst = 1'b1;
    end else begin
      case (state_q)
        ST_ADDR, ST_WR: begin
          if (scl_rise && cnt_q != CNT_W'(BYTE_W)) begin
            sh_d  = {sh_q[BYTE_W-2:0], sda_s};
            cnt_d = cnt_q + 1'b1;
          end else if (scl_fall && cnt_q == CNT_W'(BYTE_W)) begin
            if (state_q == ST_ADDR) begin
              if (sh_q[BYTE_W-1:1] == ADDR7) begin
                rw_d    = sh_q[0];
                addr_d  = 1'b1;
                sdl_d   = 1'b1;
                state_d = ST_ACK;
              end else begin
                state_d = ST_IDLE;
              end
            end else begin
              addr_d  = 1'b0;
              sdl_d   = 1'b1;
              state_d = ST_ACK;
            end
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            sdl_d   = 1'b0;
            scll_d  = 1'b1;
            hold_d  = HW'(HOLD - 1);
            state_d = ST_HOLD;
            if (rw_q) begin
              rd_evt = 1'b1;
              sh_d   = rd_byte;
              sdl_d  = ~rd_byte[BYTE_W-1];
            end else if (!addr_q) begin
              wr_evt = 1'b1;
            end
          end
        end
        ST_HOLD: begin
          if (hold_q == '0) begin
            scll_d  = 1'b0;
            cnt_d   = '0;
            state_d = rw_q ? ST_RD : ST_WR;
          end else begin
            hold_d = hold_q - 1'b1;
          end
        end
        ST_RD: begin
          if (scl_fall) begin
            if (cnt_q == CNT_W'(BYTE_W - 1)) begin
              sdl_d   = 1'b0;
              state_d = ST_RD_ACK;
            end else begin
              sh_d  = {sh_q[BYTE_W-2:0], 1'b0};
              sdl_d = ~sh_q[BYTE_W-2];
              cnt_d = cnt_q + 1'b1;
            end
          end
        end
        ST_RD_ACK: begin
          if (scl_rise) begin
            nack_d = sda_s;
          end else if (scl_fall) begin
            if (nack_q) begin
              state_d = ST_IDLE;
            end else begin
              rd_evt  = 1'b1;
              sh_d    = rd_byte;
              sdl_d   = ~rd_byte[BYTE_W-1];
              scll_d  = 1'b1;
              hold_d  = HW'(HOLD - 1);
              state_d = ST_HOLD;
            end
          end
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      sh_q    <= '0;
      hold_q  <= '0;
      rw_q    <= 1'b0;
      addr_q  <= 1'b0;
      nack_q  <= 1'b0;
      sdl_q   <= 1'b0;
      scll_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      sh_q    <= sh_d;
      hold_q  <= hold_d;
      rw_q    <= rw_d;
      addr_q  <= addr_d;
      nack_q  <= nack_d;
      sdl_q   <= sdl_d;
      scll_q  <= scll_d;
    end
  end

  assign rx_byte = sh_q;
  assign sda_low = sdl_q;
  assign scl_low = scll_q;
endmodule

// File: rtl/bank_io_regs.sv
module bank_io_regs
  import bank_io_pkg::*;
#(
  parameter int                OUT_W    = 11,
  parameter logic [BYTE_W-1:0] CODE_LO  = 8'h01,
  parameter logic [BYTE_W-1:0] CODE_HI  = 8'h02,
  parameter logic [BYTE_W-1:0] FALLBACK = 8'h00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_evt,
  input  logic              rd_evt,
  input  logic              seq_rst,
  input  logic [BYTE_W-1:0] rx_byte,
  input  logic [OUT_W-1:0]  alarm_in,
  output logic [BYTE_W-1:0] rd_byte,
  output logic [OUT_W-1:0]  out_port
);
  localparam int LO_W = BYTE_W;
  localparam int HI_W = OUT_W - LO_W;

  logic [BYTE_W-1:0] ctrl_q, ctrl_d;
  logic              phase_q, phase_d;
  logic [LO_W-1:0]   lo_q, lo_d;
  logic [HI_W-1:0]   hi_q, hi_d;

  always_comb begin
    ctrl_d  = ctrl_q;
    phase_d = phase_q;
    lo_d    = lo_q;
    hi_d    = hi_q;
    if (seq_rst) begin
      phase_d = 1'b0;
    end else if (wr_evt) begin
      if (!phase_q) begin
        ctrl_d  = rx_byte;
        phase_d = 1'b1;
      end else begin
        phase_d = 1'b0;
        if (ctrl_q == CODE_LO)      lo_d = rx_byte;
        else if (ctrl_q == CODE_HI) hi_d = rx_byte[HI_W-1:0];
      end
    end else if (rd_evt) begin
      ctrl_d = '0;
    end
  end

  always_comb begin
    if (ctrl_q == CODE_LO)      rd_byte = alarm_in[LO_W-1:0];
    else if (ctrl_q == CODE_HI) rd_byte = {{(BYTE_W-HI_W){1'b0}}, alarm_in[OUT_W-1:LO_W]};
    else                        rd_byte = FALLBACK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      phase_q <= 1'b0;
      lo_q    <= '0;
      hi_q    <= '0;
    end else begin
      ctrl_q  <= ctrl_d;
      phase_q <= phase_d;
      lo_q    <= lo_d;
      hi_q    <= hi_d;
    end
  end

  assign out_port = {hi_q, lo_q};
endmodule

// File: rtl/bank_io_slave.sv
module bank_io_slave
  import bank_io_pkg::*;
#(
  parameter logic [6:0] ADDR7       = 7'h48,
  parameter int         OUT_W       = 11,
  parameter int         HOLD        = 24,
  parameter int         SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             scl_drive_low,
  output logic             sda_drive_low,
  input  logic [OUT_W-1:0] alarm_in,
  output logic [OUT_W-1:0] out_port
);
  logic [1:0] pin_raw, pin_s, pin_q;
  assign pin_raw = {sda_i, scl_i};

  for (genvar g = 0; g < 2; g++) begin : g_line
    bank_io_line #(.STAGES(SYNC_STAGES)) u_line (
      .clk  (clk),
      .rst_n(rst_n),
      .pin  (pin_raw[g]),
      .lvl  (pin_s[g]),
      .lvl_q(pin_q[g])
    );
  end

  logic              wr_evt, rd_evt, seq_rst;
  logic [BYTE_W-1:0] rx_byte, rd_byte;

  bank_io_engine #(.ADDR7(ADDR7), .HOLD(HOLD)) u_engine (
    .clk    (clk),
    .rst_n  (rst_n),
    .scl_s  (pin_s[0]),
    .scl_q  (pin_q[0]),
    .sda_s  (pin_s[1]),
    .sda_q  (pin_q[1]),
    .rd_byte(rd_byte),
    .wr_evt (wr_evt),
    .rd_evt (rd_evt),
    .seq_rst(seq_rst),
    .rx_byte(rx_byte),
    .sda_low(sda_drive_low),
    .scl_low(scl_drive_low)
  );

  bank_io_regs #(.OUT_W(OUT_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_evt  (wr_evt),
    .rd_evt  (rd_evt),
    .seq_rst (seq_rst),
    .rx_byte (rx_byte),
    .alarm_in(alarm_in),
    .rd_byte (rd_byte),
    .out_port(out_port)
  );
endmodule

// File: rtl/bank_io_slave_chk.sv
module bank_io_slave_chk #(
  parameter int HOLD  = 24,
  parameter int OUT_W = 11
) (
  input logic             clk,
  input logic             rst_n,
  input logic             scl_i,
  input logic             scl_drive_low,
  input logic             sda_drive_low,
  input logic [OUT_W-1:0] out_port
);
  logic [15:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             run_q <= '0;
    else if (scl_drive_low) run_q <= run_q + 16'd1;
    else                    run_q <= '0;
  end

  p_out_in_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(out_port) |-> scl_drive_low);

  p_hold_len_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(scl_drive_low) |-> run_q == 16'(HOLD));

  p_hold_bounded_r8: assert property (@(posedge clk) disable iff (!rst_n)
    scl_drive_low |-> run_q < 16'(HOLD));

  p_hold_starts_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scl_drive_low) |-> !scl_i);

  p_sda_moves_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_drive_low) |-> !scl_i);
endmodule

bind bank_io_slave bank_io_slave_chk #(.HOLD(HOLD), .OUT_W(OUT_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .scl_i        (scl_i),
  .scl_drive_low(scl_drive_low),
  .sda_drive_low(sda_drive_low),
  .out_port     (out_port)
);

// File: tb/bank_io_slave_test.sv
`timescale 1ns/1ps
module bank_io_slave_test;
  localparam int Q = 6;
  localparam logic [7:0] AW = 8'h90;
  localparam logic [7:0] AR = 8'h91;

  logic        clk, rst_n, scl_m, sda_m;
  logic [10:0] alarm_in, out_port;
  logic        scl_drive_low, sda_drive_low;
  wire         scl_bus = scl_m & ~scl_drive_low;
  wire         sda_bus = sda_m & ~sda_drive_low;

  int checks, errors, hold_seen, sda_viol;
  logic [10:0] exp_out;
  logic        prev_sdl, done;

  bank_io_slave uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_bus), .sda_i(sda_bus),
    .scl_drive_low(scl_drive_low), .sda_drive_low(sda_drive_low),
    .alarm_in(alarm_in), .out_port(out_port)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  always @(posedge clk) begin
    if (scl_m && !scl_bus) hold_seen <= hold_seen + 1;
    if (rst_n && sda_drive_low != prev_sdl && scl_bus) sda_viol <= sda_viol + 1;
    prev_sdl <= sda_drive_low;
  end

  function automatic logic [10:0] model_apply(logic [10:0] cur, logic [7:0] c, logic [7:0] d);
    if (c == 8'h01)      return {cur[10:8], d};
    else if (c == 8'h02) return {d[2:0], cur[7:0]};
    else                 return cur;
  endfunction

  function automatic logic [7:0] model_read(logic [7:0] c, logic [10:0] a);
    if (c == 8'h01)      return a[7:0];
    else if (c == 8'h02) return {5'b0, a[10:8]};
    else                 return 8'h00;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic hq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic wait_high();
    while (!scl_bus) @(negedge clk);
  endtask

  task automatic clock_bit(input logic b, output logic r);
    sda_m = b; hq();
    scl_m = 1'b1; @(negedge clk); wait_high(); hq();
    r = sda_bus; hq();
    scl_m = 1'b0; hq();
  endtask

  task automatic bus_start();
    sda_m = 1'b1; hq();
    scl_m = 1'b1; @(negedge clk); wait_high(); hq();
    sda_m = 1'b0; hq();
    scl_m = 1'b0; hq();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; hq();
    scl_m = 1'b1; @(negedge clk); wait_high(); hq();
    sda_m = 1'b1; hq();
  endtask

  task automatic wr_byte(input logic [7:0] v, output logic acked);
    logic r;
    for (int i = 7; i >= 0; i--) clock_bit(v[i], r);
    clock_bit(1'b1, r);
    acked = !r;
  endtask

  task automatic rd_byte(input logic mack, output logic [7:0] v);
    logic r;
    for (int i = 0; i < 8; i++) begin
      clock_bit(1'b1, r);
      v = {v[6:0], r};
    end
    clock_bit(!mack, r);
  endtask

  task automatic do_write(input logic [7:0] c, input logic [7:0] d, input string req);
    logic a0, a1, a2;
    hold_seen = 0;
    bus_start();
    wr_byte(AW, a0); wr_byte(c, a1); wr_byte(d, a2);
    bus_stop();
    exp_out = model_apply(exp_out, c, d);
    chk({req, " ack"}, {a0, a1, a2}, 3'b111);
    chk({req, " out"}, out_port, exp_out);
  endtask

  task automatic do_read(input logic [7:0] c, input string req);
    logic a0, a1, a2;
    logic [7:0] v;
    bus_start();
    wr_byte(AW, a0); wr_byte(c, a1);
    bus_start();
    wr_byte(AR, a2);
    rd_byte(1'b0, v);
    chk({req, " R10 released after NACK"}, sda_drive_low, 0);
    bus_stop();
    chk({req, " ack"}, {a0, a1, a2}, 3'b111);
    chk({req, " data"}, v, model_read(c, alarm_in));
  endtask

  initial begin
    done = 1'b0;
    #(200000 * 20);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic a0, a1, a2;
    logic [7:0] v, c, d;
    checks = 0; errors = 0; hold_seen = 0; sda_viol = 0; prev_sdl = 1'b0;
    rst_n = 1'b0; scl_m = 1'b1; sda_m = 1'b1; alarm_in = '0; exp_out = '0;
    void'($urandom(32'h5EED));
    repeat (5) @(negedge clk);
    chk("R12 out", out_port, 0);
    chk("R12 lines", {scl_drive_low, sda_drive_low}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R12 out after release", out_port, 0);

    do_write(8'h01, 8'hA5, "R3");
    chk("R8 hold seen", hold_seen > 0, 1);
    do_write(8'h02, 8'hFD, "R4");
    do_write(8'h37, 8'hFF, "R5");

    // R1: foreign address
    hold_seen = 0;
    bus_start(); wr_byte(8'h84, a0); bus_stop();
    chk("R1 no ack", a0, 0);
    chk("R1 no hold", hold_seen, 0);
    chk("R1 out", out_port, exp_out);

    // R2: control/data then control/data in one transfer
    bus_start();
    wr_byte(AW, a0); wr_byte(8'h01, a1); wr_byte(8'h0F, a2);
    wr_byte(8'h02, a1); wr_byte(8'h06, a2);
    bus_stop();
    exp_out = model_apply(model_apply(exp_out, 8'h01, 8'h0F), 8'h02, 8'h06);
    chk("R2 out", out_port, exp_out);
    chk("R10 data ack", a2, 1);

    // R9: STOP after control byte restarts the order
    bus_start(); wr_byte(AW, a0); wr_byte(8'h01, a1); bus_stop();
    bus_start(); wr_byte(AW, a0); wr_byte(8'h02, a1); wr_byte(8'h01, a2); bus_stop();
    exp_out = model_apply(exp_out, 8'h02, 8'h01);
    chk("R9 out", out_port, exp_out);

    alarm_in = 11'h5C3;
    do_read(8'h01, "R6 R9 lo");
    do_read(8'h02, "R6 hi");
    do_read(8'h7E, "R6 other");

    // R7: second byte of a read and a read without new control give 0x00
    bus_start(); wr_byte(AW, a0); wr_byte(8'h01, a1);
    bus_start(); wr_byte(AR, a2);
    rd_byte(1'b1, v);
    chk("R7 first", v, 8'hC3);
    rd_byte(1'b0, v);
    chk("R7 second", v, 8'h00);
    bus_stop();
    bus_start(); wr_byte(AR, a2); rd_byte(1'b0, v); bus_stop();
    chk("R7 fresh read", v, 8'h00);

    for (int n = 0; n < 24; n++) begin
      case ($urandom % 3)
        0: c = 8'h01;
        1: c = 8'h02;
        default: c = 8'($urandom);
      endcase
      d = 8'($urandom);
      alarm_in = 11'($urandom);
      if ($urandom % 2) do_write(c, d, "R3 R4 R5 random");
      else              do_read(c, "R6 random");
    end

    chk("R11 sda moves while SCL high", sda_viol, 0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule